// File: doc/BRIEF.md
# Flash Write-Buffer Program Sequencer

This block is the host-side engine for one buffered programming job on an asynchronous NOR-style flash bus. A single-cycle start pulse hands it a start address, which names both the target sector and the first buffer location, and a word count. It checks that the request fits inside one aligned 16-word page. If it fits, the block emits the unlock pair, the buffer-load command, the count minus one, the data writes and the confirm command. It fetches each data word from the host by index as it goes.

After the confirm command it keeps re-reading the last loaded address. The job is settled when bit 7 of the read value equals bit 7 of the word written there. If bit 1 or bit 5 comes back set, it takes exactly one more read to tell a late success from a real error. On an error it writes the recovery sequence that suits the cause: the three-write abort reset after bit 1, or a one-write software reset after bit 5 or after too many polls. One bus cycle takes `CYC_CLKS` clocks. The strobe is high for all clocks of the cycle except the last, so consecutive cycles are always separated.

Top module: `wbuf_prog_seq`

## Requirements
- R1: After reset, busy, done, every result flag and both strobes are low.
- R2: An accepted job writes, in this order: AAh at 555h, 55h at 2AAh, 25h at the start address, (count-1) at the start address, the data writes, and 29h at the start address.
- R3: Data write i (0-based) goes to start address + i and carries the word the host presents on `wd_data` while `wd_idx` equals i.
- R4: A start with count 0, count above 16, or start offset within the page + count above 16 is rejected. The block raises `res_err` and done, and makes no bus cycle.
- R5: Every poll read addresses start address + count - 1. A read whose bit 7 equals bit 7 of the last data word ends the job with `res_pass`, and no reset writes follow.
- R6: A poll read with bit 7 mismatched and bits 1 and 5 clear is followed by another poll read.
- R7: A poll read with bit 7 mismatched and bit 1 or bit 5 set is followed by exactly one re-read. If the re-read's bit 7 matches, the result is pass.
- R8: If bit 1 was set and the re-read mismatches, `res_abort` is set and the block writes AAh at 555h, 55h at 2AAh, then F0h at 555h.
- R9: If only bit 5 was set and the re-read mismatches, `res_fail` is set and the block writes a single F0h at address 0.
- R10: After `POLL_MAX` poll reads with no match and no flag bit, `res_fail` is set and the single F0h write at address 0 follows.
- R11: Each bus cycle lasts `CYC_CLKS` clocks, with its strobe high for the first `CYC_CLKS`-1. Address and data are steady while a write strobe is high. Read and write strobes are never high together, and neither is high while idle.
- R12: busy is high from the clock after an accepted start until done. done is a one-clock pulse during which exactly one result flag is high. The flags hold until the next start, and a start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request pulse, used only while idle |
| start_addr | input | ADDR_W | Sector address and first buffer location |
| word_cnt | input | $clog2(PAGE_WORDS+1) | Number of words to program |
| wd_req | output | 1 | High during a data write cycle |
| wd_idx | output | $clog2(PAGE_WORDS) | Index of the requested data word |
| wd_data | input | DATA_W | Requested data word from the host |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | DATA_W | Flash bus write data |
| fl_we | output | 1 | Write strobe |
| fl_re | output | 1 | Read strobe |
| fl_rdata | input | DATA_W | Flash bus read data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-clock completion pulse |
| res_pass | output | 1 | Job programmed successfully |
| res_fail | output | 1 | Device failure or poll timeout |
| res_abort | output | 1 | Device reported buffer abort |
| res_err | output | 1 | Request rejected without bus activity |

## Verification
The hardest case to reach is the second-chance read. A flag bit must show up while bit 7 still mismatches, and the very next read must then either match (late pass) or keep mismatching. Each cause also needs its own recovery sequence. The bench's flash model follows a per-job script: a chosen number of busy reads, then a read with bit 1 or bit 5 set, then a re-read whose bit 7 the script picks. Directed jobs cover each script. Random jobs mix the scripts with random page offsets and counts, and one job pulses start mid-run with an illegal count.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_UL1, S_UL2, S_LDCMD, S_CNT, S_DATA, S_CONF,
        S_POLL, S_REPOLL, S_AR1, S_AR2, S_AR3, S_SWR, S_DONE
    } wbs_state_e;

    typedef enum logic [1:0] {
        PV_BUSY, PV_MATCH, PV_FLAG
    } poll_verdict_e;

    localparam logic [11:0] ADR_UNLK_A = 12'h555;
    localparam logic [11:0] ADR_UNLK_B = 12'h2AA;
    localparam logic [7:0]  CMD_UNLK_A = 8'hAA;
    localparam logic [7:0]  CMD_UNLK_B = 8'h55;
    localparam logic [7:0]  CMD_LOAD   = 8'h25;
    localparam logic [7:0]  CMD_CONF   = 8'h29;
    localparam logic [7:0]  CMD_RESET  = 8'hF0;

    function automatic logic st_writes(wbs_state_e s);
        return (s == S_UL1) || (s == S_UL2) || (s == S_LDCMD) || (s == S_CNT) ||
               (s == S_DATA) || (s == S_CONF) || (s == S_AR1) || (s == S_AR2) ||
               (s == S_AR3) || (s == S_SWR);
    endfunction

    function automatic logic st_reads(wbs_state_e s);
        return (s == S_POLL) || (s == S_REPOLL);
    endfunction

endpackage

// File: rtl/wbs_beat_timer.sv
module wbs_beat_timer #(
    parameter int CYC_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic strobe_on,
    output logic last
);
    localparam int CW = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;

    logic [CW-1:0] cnt;

    assign last      = run && (cnt == CW'(CYC_CLKS - 1));
    assign strobe_on = run && !last;

    always_ff @(posedge clk) begin
        if (rst || !run || last) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wbs_req_check.sv
module wbs_req_check #(
    parameter int PAGE_WORDS = 16
) (
    input  logic [$clog2(PAGE_WORDS)-1:0]   offset,
    input  logic [$clog2(PAGE_WORDS+1)-1:0] count,
    output logic                            ok
);
    localparam int OFF_W = $clog2(PAGE_WORDS);
    localparam int CNT_W = $clog2(PAGE_WORDS + 1);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] span;

    always_comb begin
        span = SUM_W'(offset) + SUM_W'(count);
        ok   = (count != '0) &&
               (SUM_W'(count) <= SUM_W'(PAGE_WORDS)) &&
               (span <= SUM_W'(PAGE_WORDS));
    end

    logic unused_w;
    assign unused_w = (OFF_W == 0);
endmodule

// File: rtl/wbs_poll_judge.sv
module wbs_poll_judge
    import wbs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic              exp7,
    output poll_verdict_e     verdict,
    output logic              dq1_seen
);
    logic unused_rd;
    assign unused_rd = ^rdata;

    always_comb begin
        dq1_seen = rdata[1];
        if (rdata[7] == exp7)        verdict = PV_MATCH;
        else if (rdata[1] | rdata[5]) verdict = PV_FLAG;
        else                          verdict = PV_BUSY;
    end
endmodule

// File: rtl/wbuf_prog_seq.sv
module wbuf_prog_seq
    import wbs_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int PAGE_WORDS = 16,
    parameter int CYC_CLKS   = 4,
    parameter int POLL_MAX   = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic [ADDR_W-1:0]               start_addr,
    input  logic [$clog2(PAGE_WORDS+1)-1:0] word_cnt,
    output logic                            wd_req,
    output logic [$clog2(PAGE_WORDS)-1:0]   wd_idx,
    input  logic [DATA_W-1:0]               wd_data,
    output logic [ADDR_W-1:0]               fl_addr,
    output logic [DATA_W-1:0]               fl_wdata,
    output logic                            fl_we,
    output logic                            fl_re,
    input  logic [DATA_W-1:0]               fl_rdata,
    output logic                            busy,
    output logic                            done,
    output logic                            res_pass,
    output logic                            res_fail,
    output logic                            res_abort,
    output logic                            res_err
);
    localparam int OFF_W = $clog2(PAGE_WORDS);
    localparam int CNT_W = $clog2(PAGE_WORDS + 1);
    localparam int PC_W  = $clog2(POLL_MAX + 1);

    wbs_state_e       state;
    logic [ADDR_W-1:0] sa_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [OFF_W-1:0]  idx;
    logic              exp7;
    logic [PC_W-1:0]   pcnt;
    logic              saw_dq1;

    logic          req_ok;
    logic          beat_run, strobe_on, beat_last;
    poll_verdict_e verdict;
    logic          dq1_now;
    logic [ADDR_W-1:0] last_addr;

    wbs_req_check #(.PAGE_WORDS(PAGE_WORDS)) u_req (
        .offset (start_addr[OFF_W-1:0]),
        .count  (word_cnt),
        .ok     (req_ok)
    );

    assign beat_run = st_writes(state) || st_reads(state);

    wbs_beat_timer #(.CYC_CLKS(CYC_CLKS)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .run       (beat_run),
        .strobe_on (strobe_on),
        .last      (beat_last)
    );

    wbs_poll_judge #(.DATA_W(DATA_W)) u_judge (
        .rdata    (fl_rdata),
        .exp7     (exp7),
        .verdict  (verdict),
        .dq1_seen (dq1_now)
    );

    assign last_addr = sa_q + ADDR_W'(cnt_q) - ADDR_W'(1);
    assign fl_we     = st_writes(state) && strobe_on;
    assign fl_re     = st_reads(state) && strobe_on;
    assign wd_req    = (state == S_DATA);
    assign wd_idx    = idx;
    assign busy      = (state != S_IDLE);
    assign done      = (state == S_DONE);

    always_comb begin
        fl_addr  = '0;
        fl_wdata = '0;
        unique case (state)
            S_UL1, S_AR1: begin
                fl_addr = ADDR_W'(ADR_UNLK_A); fl_wdata = DATA_W'(CMD_UNLK_A);
            end
            S_UL2, S_AR2: begin
                fl_addr = ADDR_W'(ADR_UNLK_B); fl_wdata = DATA_W'(CMD_UNLK_B);
            end
            S_LDCMD: begin fl_addr = sa_q; fl_wdata = DATA_W'(CMD_LOAD); end
            S_CNT:   begin fl_addr = sa_q; fl_wdata = DATA_W'(cnt_q - 1'b1); end
            S_DATA:  begin fl_addr = sa_q + ADDR_W'(idx); fl_wdata = wd_data; end
            S_CONF:  begin fl_addr = sa_q; fl_wdata = DATA_W'(CMD_CONF); end
            S_POLL, S_REPOLL: fl_addr = last_addr;
            S_AR3:   begin fl_addr = ADDR_W'(ADR_UNLK_A); fl_wdata = DATA_W'(CMD_RESET); end
            S_SWR:   fl_wdata = DATA_W'(CMD_RESET);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            sa_q      <= '0;
            cnt_q     <= '0;
            idx       <= '0;
            exp7      <= 1'b0;
            pcnt      <= '0;
            saw_dq1   <= 1'b0;
            res_pass  <= 1'b0;
            res_fail  <= 1'b0;
            res_abort <= 1'b0;
            res_err   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    res_pass  <= 1'b0;
                    res_fail  <= 1'b0;
                    res_abort <= 1'b0;
                    sa_q      <= start_addr;
                    cnt_q     <= word_cnt;
                    idx       <= '0;
                    pcnt      <= '0;
                    saw_dq1   <= 1'b0;
                    res_err   <= !req_ok;
                    state     <= req_ok ? S_UL1 : S_DONE;
                end
                S_UL1:   if (beat_last) state <= S_UL2;
                S_UL2:   if (beat_last) state <= S_LDCMD;
                S_LDCMD: if (beat_last) state <= S_CNT;
                S_CNT:   if (beat_last) state <= S_DATA;
                S_DATA: if (beat_last) begin
                    if (idx == OFF_W'(cnt_q - 1'b1)) begin
                        exp7  <= wd_data[7];
                        state <= S_CONF;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_CONF: if (beat_last) state <= S_POLL;
                S_POLL: if (beat_last) begin
                    pcnt <= pcnt + 1'b1;
                    unique case (verdict)
                        PV_MATCH: begin res_pass <= 1'b1; state <= S_DONE; end
                        PV_FLAG:  begin saw_dq1 <= dq1_now; state <= S_REPOLL; end
                        default: if (pcnt == PC_W'(POLL_MAX - 1)) begin
                            res_fail <= 1'b1;
                            state    <= S_SWR;
                        end
                    endcase
                end
                S_REPOLL: if (beat_last) begin
                    if (verdict == PV_MATCH) begin
                        res_pass <= 1'b1;
                        state    <= S_DONE;
                    end else if (saw_dq1) begin
                        res_abort <= 1'b1;
                        state     <= S_AR1;
                    end else begin
                        res_fail <= 1'b1;
                        state    <= S_SWR;
                    end
                end
                S_AR1: if (beat_last) state <= S_AR2;
                S_AR2: if (beat_last) state <= S_AR3;
                S_AR3: if (beat_last) state <= S_DONE;
                S_SWR: if (beat_last) state <= S_DONE;
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wbs_seq_checker.sv
module wbs_seq_checker #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [DATA_W-1:0] fl_wdata,
    input logic              fl_we,
    input logic              fl_re,
    input logic              busy,
    input logic              done,
    input logic              res_pass,
    input logic              res_fail,
    input logic              res_abort,
    input logic              res_err
);
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fl_we && !fl_re));

    p_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (fl_we && $past(fl_we)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_result_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot({res_pass, res_fail, res_abort, res_err}));

    p_flag_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({res_pass, res_fail, res_abort, res_err}));

    p_err_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        res_err |-> (!fl_we && !fl_re));

    p_flags_excl_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_pass, res_fail, res_abort, res_err}));
endmodule

bind wbuf_prog_seq wbs_seq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .busy(busy), .done(done), .res_pass(res_pass),
    .res_fail(res_fail), .res_abort(res_abort), .res_err(res_err)
);

// File: tb/sim_wbuf_prog_seq.sv
module sim_wbuf_prog_seq;
    localparam int AW = 20, DW = 16, PW = 16, CYC = 4, PMAX = 32;
    localparam int M_PASS = 0, M_F5 = 1, M_A1 = 2, M_L5 = 3, M_L1 = 4, M_TO = 5, M_REJ = 6;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [4:0] word_cnt = '0;
    logic wd_req, fl_we, fl_re, busy, done, res_pass, res_fail, res_abort, res_err;
    logic [3:0] wd_idx;
    logic [DW-1:0] wd_data, fl_wdata;
    logic [DW-1:0] fl_rdata = '0;
    logic [AW-1:0] fl_addr;

    wbuf_prog_seq u0 (.clk, .rst, .start, .start_addr, .word_cnt, .wd_req, .wd_idx,
        .wd_data, .fl_addr, .fl_wdata, .fl_we, .fl_re, .fl_rdata, .busy, .done,
        .res_pass, .res_fail, .res_abort, .res_err);

    always #5 clk = ~clk;

    logic [DW-1:0] mem [PW];
    assign wd_data = mem[wd_idx];

    int total = 0, bad = 0;
    int mode = 0, busy_n = 0, rd_n = 0, rd_bad = 0, wn = 0, wrun = 0, wwidth_bad = 0;
    logic e7 = 1'b0;
    logic [AW-1:0] exp_raddr = '0;
    logic [AW-1:0] la [64];
    logic [DW-1:0] ld [64];
    logic we_q = 1'b0, re_q = 1'b0;

    function automatic logic [DW-1:0] resp(int k);
        logic [DW-1:0] d = '0;
        d[6] = k[0];
        d[7] = ~e7;
        if (mode == M_TO || k <= busy_n) return d;
        if (k == busy_n + 1) begin
            if (mode == M_PASS) d[7] = e7;
            else if (mode == M_F5 || mode == M_L5) d[5] = 1'b1;
            else d[1] = 1'b1;
        end else begin
            if (mode == M_L5 || mode == M_L1) d[7] = e7;
            else if (mode == M_F5) d[5] = 1'b1;
            else d[1] = 1'b1;
        end
        return d;
    endfunction

    always @(negedge clk) begin
        if (fl_we && !we_q && wn < 64) begin la[wn] = fl_addr; ld[wn] = fl_wdata; wn++; end
        if (fl_we) wrun++;
        else if (we_q) begin if (wrun != CYC - 1) wwidth_bad++; wrun = 0; end
        if (fl_re && !re_q) begin
            rd_n++;
            if (fl_addr != exp_raddr) rd_bad++;
            fl_rdata = resp(rd_n);
        end
        we_q = fl_we;
        re_q = fl_re;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic run_job(input logic [AW-1:0] sa, input int cnt, input int md,
                           input int bn, input bit poke);
        logic [AW-1:0] ea [64];
        logic [DW-1:0] ed [64];
        int en = 0, exp_rd = 0, cyc = 0, mis_cmd = 0, mis_dat = 0, mis_rst = 0, lim;
        logic [3:0] fl;
        for (int i = 0; i < PW; i++) mem[i] = DW'($urandom);
        mode = md; busy_n = bn;
        e7 = (cnt >= 1 && cnt <= PW) ? mem[cnt-1][7] : 1'b0;
        exp_raddr = sa + AW'(cnt) - AW'(1);
        if (md != M_REJ) begin
            ea[0] = AW'(12'h555); ed[0] = 16'hAA;
            ea[1] = AW'(12'h2AA); ed[1] = 16'h55;
            ea[2] = sa; ed[2] = 16'h25;
            ea[3] = sa; ed[3] = DW'(cnt - 1);
            for (int i = 0; i < cnt; i++) begin ea[4+i] = sa + AW'(i); ed[4+i] = mem[i]; end
            ea[4+cnt] = sa; ed[4+cnt] = 16'h29;
            en = 5 + cnt;
            if (md == M_A1) begin
                ea[en] = AW'(12'h555); ed[en] = 16'hAA;
                ea[en+1] = AW'(12'h2AA); ed[en+1] = 16'h55;
                ea[en+2] = AW'(12'h555); ed[en+2] = 16'hF0;
                en += 3;
            end else if (md == M_F5 || md == M_TO) begin
                ea[en] = '0; ed[en] = 16'hF0; en += 1;
            end
            exp_rd = (md == M_PASS) ? bn + 1 : (md == M_TO) ? PMAX : bn + 2;
        end
        fl = (md == M_REJ) ? 4'b0001 : (md == M_A1) ? 4'b0010 :
             (md == M_F5 || md == M_TO) ? 4'b0100 : 4'b1000;

        @(negedge clk);
        wn = 0; rd_n = 0; rd_bad = 0;
        start_addr = sa; word_cnt = 5'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R12 busy after start", busy, 1);
        lim = 20000;
        while (!done && cyc < lim) begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 7);
            if (poke && cyc == 7) word_cnt = 5'd0;
        end
        if (!done) begin
            chk(1'b0, "R12 job never finished", cyc, lim);
            return;
        end
        chk({res_pass, res_fail, res_abort, res_err} == fl,
            (md == M_REJ) ? "R4 reject flag" : (md == M_A1) ? "R8 abort flag" :
            (md == M_F5) ? "R9 fail flag" : (md == M_TO) ? "R10 timeout flag" :
            (md == M_PASS) ? "R5 pass flag" : "R7 late pass flag",
            {res_pass, res_fail, res_abort, res_err}, fl);
        chk(wn == en, (md == M_REJ) ? "R4 no bus writes" : "R2 write count", wn, en);
        chk(rd_n == exp_rd, (md == M_TO) ? "R10 poll reads" :
            (bn > 0) ? "R6 poll reads" : "R7 poll reads", rd_n, exp_rd);
        chk(rd_bad == 0, "R5 poll address", rd_bad, 0);
        for (int i = 0; i < en && i < wn; i++) begin
            if (la[i] != ea[i] || ld[i] != ed[i]) begin
                if (i < 4 || i == 4 + cnt) mis_cmd++;
                else if (i < 4 + cnt) mis_dat++;
                else mis_rst++;
            end
        end
        if (md != M_REJ) begin
            chk(mis_cmd == 0, "R2 command cycles", mis_cmd, 0);
            chk(mis_dat == 0, "R3 data cycles", mis_dat, 0);
            chk(mis_rst == 0, (md == M_A1) ? "R8 abort reset" :
                (md == M_F5) ? "R9 software reset" : (md == M_TO) ? "R10 software reset" :
                "R5 no reset writes", mis_rst, 0);
        end
        @(negedge clk);
        chk(!done && !busy, "R12 done single pulse", {done, busy}, 0);
        chk({res_pass, res_fail, res_abort, res_err} == fl, "R12 flags hold",
            {res_pass, res_fail, res_abort, res_err}, fl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, res_pass, res_fail, res_abort, res_err, fl_we, fl_re} == 8'b0,
            "R1 reset state", {busy, done, res_pass, res_fail, res_abort, res_err, fl_we, fl_re}, 0);

        run_job(20'h1_2340, 16, M_PASS, 0, 0);
        run_job(20'h0_05AF, 1, M_PASS, 5, 0);
        run_job(20'h3_3304, 6, M_F5, 2, 0);
        run_job(20'h4_4401, 9, M_A1, 1, 0);
        run_job(20'h5_5508, 4, M_L5, 3, 0);
        run_job(20'h6_6600, 2, M_L1, 0, 0);
        run_job(20'h7_770C, 3, M_TO, 0, 0);
        run_job(20'h0_1000, 0, M_REJ, 0, 0);
        run_job(20'h0_1000, 17, M_REJ, 0, 0);
        run_job(20'h0_100A, 7, M_REJ, 0, 0);
        run_job(20'h0_100A, 6, M_PASS, 2, 1);
        chk(wwidth_bad == 0, "R11 strobe width", wwidth_bad, 0);

        for (int j = 0; j < 20; j++) begin
            int off = $urandom_range(0, 15);
            int cnt = $urandom_range(1, 16 - off);
            logic [AW-1:0] sa = {16'($urandom), 4'(off)};
            run_job(sa, cnt, $urandom_range(0, 4), $urandom_range(0, 6), 0);
        end
        chk(wwidth_bad == 0, "R11 strobe width random", wwidth_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule